// File: doc/BRIEF.md
# Two-Cycle 8-Bit Register-Move Processor Core

This block is a very small processor core with an 8-bit data path. It fetches a 16-bit instruction word from an external program store through an 8-bit address and runs it. The upper byte is the opcode and the lower byte is the operand. Every instruction takes exactly two clock cycles. In the first cycle the core captures the word at the current address. In the second cycle it executes that word and advances the program counter.

The core has three general registers, R0 to R2, and two ALU operand registers, A and B. It also holds a program counter and a single zero flag. The ALU reads only A and B. A calculation is therefore a short sequence: load A, load B, then add or subtract into a chosen general register. A compare is a subtract that updates the flag and writes no register. Branches jump to an absolute 8-bit address, either always or when the zero flag has a given value.

Debug outputs show every architectural register, so a system or a bench can watch execution.

Top module: `tiny_core`

## Requirements
- R1: While `rstN` is low, the program counter, R0–R2, A, B and the zero flag are all zero.
- R2: The word on `instrWord` is captured in the first cycle of an instruction, and its value during the second cycle has no effect. `instrAddr` holds steady for both cycles. At the end of the second cycle it becomes the old value plus one, modulo 256, unless a branch is taken.
- R3: Register move, opcode bits 7–5 = 000. Bits 3–2 name the destination (0–2). With bit 4 set, the operand byte is loaded. With bit 4 clear, the register named by bits 1–0 is copied. For example, 0x13 0x0A puts 10 into R0.
- R4: Move to ALU, bits 7–5 = 001 with bit 3 = 0. Bit 2 picks A (0) or B (1). The source follows the same rule as R3: the operand byte when bit 4 is set, otherwise the register named by bits 1–0.
- R5: Arithmetic, bits 7–5 = 010. Bit 0 picks A+B (0) or A−B (1), modulo 256. The result goes to the register named by bits 3–2. The zero flag is set exactly when the 8-bit result is zero.
- R6: Opcode 0x4D (arithmetic, destination code 3, subtract) is a compare. It updates the zero flag from A−B and writes no register.
- R7: Branch, bits 7–5 = 111, with the operand byte as the target.
  - With bit 3 clear, the branch is always taken (0xF0).
  - With bit 3 set, it is taken only when the zero flag equals bit 2 (0xF8 branches on zero clear, 0xFC on zero set).
  - When a branch is not taken, the program counter steps by one.
- R8: Move instructions never change the zero flag, so 0x0000 acts as a no-op.
- R9: The following instructions change nothing but the program counter, which steps by one:
  - classes 011, 100, 101 and 110;
  - a register move or addition whose destination code is 3;
  - a move whose source code is 3 while bit 4 is clear;
  - a move to ALU with bit 3 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instrAddr | output | 8 | Program counter, address of the next instruction word |
| instrWord | input | 16 | Instruction word at `instrAddr`; opcode in bits 15–8, operand in bits 7–0 |
| dbgR0 | output | 8 | General register R0 |
| dbgR1 | output | 8 | General register R1 |
| dbgR2 | output | 8 | General register R2 |
| dbgA | output | 8 | ALU operand register A |
| dbgB | output | 8 | ALU operand register B |
| dbgZ | output | 1 | Zero flag |

## Verification
The assertions assume that the program store answers combinationally, so `instrWord` is valid in the fetch cycle for the address shown. They also assume that reset is held long enough to clear the two-phase sequencer.

The bench presents each instruction word during the fetch cycle of its slot. During the execute cycle it drives a deliberately harmful branch word, so any use of the live input instead of the captured one shows up at once. The instructions are given in order and branch targets are checked through `instrAddr`, so no program store has to follow the branches.

// File: rtl/tiny_core_pkg.sv
package tiny_core_pkg;
  localparam int DW     = 8;              // data and address width
  localparam int IW     = 2 * DW;         // instruction word: opcode byte + operand byte
  localparam int NREG   = 3;              // general registers
  localparam int RSEL_W = $clog2(NREG + 1);

  typedef enum logic [2:0] {
    CLS_MOVREG = 3'b000,
    CLS_MOVALU = 3'b001,
    CLS_ARITH  = 3'b010,
    CLS_BRANCH = 3'b111
  } instr_class_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              regWe;    // write a general register
    logic              aluWe;    // write A or B
    logic              zWe;      // update zero flag
    logic              pcEn;     // advance or load PC
    logic              jump;     // load PC from operand
    logic              fromAlu;  // register write takes ALU result
    logic              sub;      // ALU subtracts
    logic              useImm;   // source is operand byte
    logic              aluDstB;  // ALU register write goes to B
    logic [RSEL_W-1:0] dst;
    logic [RSEL_W-1:0] src;
    logic [DW-1:0]     imm;
  } ctl_t;
endpackage

// File: rtl/tiny_core_ctrl.sv
module tiny_core_ctrl
  import tiny_core_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] instrWord,
  input  logic          zFlag,
  output ctl_t          ctl
);
  logic          execPhase;
  logic [IW-1:0] ir;
  logic [DW-1:0] op;
  instr_class_e  cls;
  logic          srcOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execPhase <= 1'b0;
      ir        <= '0;
    end else begin
      execPhase <= !execPhase;
      if (!execPhase) ir <= instrWord;
    end
  end

  assign op    = ir[IW-1:DW];
  assign cls   = instr_class_e'(op[7:5]);
  assign srcOk = op[4] || (op[1:0] != 2'b11);

  always_comb begin
    ctl         = '0;
    ctl.imm     = ir[DW-1:0];
    ctl.dst     = op[3:2];
    ctl.src     = op[1:0];
    ctl.useImm  = op[4];
    ctl.sub     = op[0];
    ctl.aluDstB = op[2];
    if (execPhase) begin
      ctl.pcEn = 1'b1;
      case (cls)
        CLS_MOVREG: ctl.regWe = (op[3:2] != 2'b11) && srcOk;
        CLS_MOVALU: ctl.aluWe = !op[3] && srcOk;
        CLS_ARITH: begin
          if (op[3:2] != 2'b11) begin
            ctl.regWe   = 1'b1;
            ctl.fromAlu = 1'b1;
            ctl.zWe     = 1'b1;
          end else begin
            ctl.zWe = op[0];               // compare
          end
        end
        CLS_BRANCH: ctl.jump = !op[3] || (zFlag == op[2]);
        default: ;
      endcase
    end
  end

  // R6: the compare opcode updates the flag and writes nothing
  a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (execPhase && op == 8'h4D) |-> (ctl.zWe && !ctl.regWe && !ctl.aluWe));

  // R9: unused classes raise no write strobe
  a_r9_unused_class_idle: assert property (@(posedge clk) disable iff (!rstN)
    (execPhase && op[7:5] inside {3'b011, 3'b100, 3'b101, 3'b110})
      |-> !(ctl.regWe || ctl.aluWe || ctl.zWe || ctl.jump));

  // R2: nothing is written during the fetch cycle
  a_r2_fetch_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !execPhase |-> !(ctl.regWe || ctl.aluWe || ctl.zWe || ctl.pcEn));
endmodule

// File: rtl/tiny_core_dpath.sv
module tiny_core_dpath
  import tiny_core_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  output logic [DW-1:0] pc,
  output logic          zFlag,
  output logic [DW-1:0] gprOut [NREG],
  output logic [DW-1:0] aReg,
  output logic [DW-1:0] bReg
);
  logic [DW-1:0] gpr [NREG];
  logic [DW-1:0] srcVal;
  logic [DW-1:0] aluRes;
  logic [DW-1:0] wrVal;

  always_comb begin
    srcVal = '0;
    if (ctl.useImm) srcVal = ctl.imm;
    else if (int'(ctl.src) < NREG) srcVal = gpr[ctl.src];
  end

  assign aluRes = ctl.sub ? (aReg - bReg) : (aReg + bReg);
  assign wrVal  = ctl.fromAlu ? aluRes : srcVal;

  for (genvar i = 0; i < NREG; i++) begin : g_gpr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) gpr[i] <= '0;
      else if (ctl.regWe && int'(ctl.dst) == i) gpr[i] <= wrVal;
    end
    assign gprOut[i] = gpr[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg  <= '0;
      bReg  <= '0;
      zFlag <= 1'b0;
      pc    <= '0;
    end else begin
      if (ctl.aluWe && !ctl.aluDstB) aReg <= srcVal;
      if (ctl.aluWe &&  ctl.aluDstB) bReg <= srcVal;
      if (ctl.zWe) zFlag <= (aluRes == '0);
      if (ctl.pcEn) pc <= ctl.jump ? ctl.imm : pc + 1'b1;
    end
  end

  // R8: moves leave the flag alone
  a_r8_move_keeps_z: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.regWe && !ctl.fromAlu) || ctl.aluWe) |=> $stable(zFlag));

  // R5: after arithmetic the flag reflects the stored result
  a_r5_z_tracks_result: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.zWe && ctl.regWe) |=> (zFlag == (gpr[$past(ctl.dst)] == '0)));

  // R7: a taken branch lands on the operand
  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcEn && ctl.jump) |=> (pc == $past(ctl.imm)));

  // R2: sequential step wraps modulo 256
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcEn && !ctl.jump) |=> (pc == DW'($past(pc) + 1)));
endmodule

// File: rtl/tiny_core.sv
module tiny_core
  import tiny_core_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  output logic [DW-1:0] instrAddr,
  input  logic [IW-1:0] instrWord,
  output logic [DW-1:0] dbgR0,
  output logic [DW-1:0] dbgR1,
  output logic [DW-1:0] dbgR2,
  output logic [DW-1:0] dbgA,
  output logic [DW-1:0] dbgB,
  output logic          dbgZ
);
  ctl_t          ctl;
  logic          zFlag;
  logic [DW-1:0] gprOut [NREG];

  tiny_core_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .zFlag     (zFlag),
    .ctl       (ctl)
  );

  tiny_core_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .pc     (instrAddr),
    .zFlag  (zFlag),
    .gprOut (gprOut),
    .aReg   (dbgA),
    .bReg   (dbgB)
  );

  assign dbgR0 = gprOut[0];
  assign dbgR1 = gprOut[1];
  assign dbgR2 = gprOut[2];
  assign dbgZ  = zFlag;
endmodule

// File: tb/tiny_core_test.sv
`timescale 1ns/1ps
module tiny_core_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  instrAddr;
  logic [15:0] instrWord = 16'h0000;
  logic [7:0]  dbgR0, dbgR1, dbgR2, dbgA, dbgB;
  logic        dbgZ;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #2.5 clk = !clk;   // 200 MHz

  tiny_core uut (
    .clk(clk), .rstN(rstN), .instrAddr(instrAddr), .instrWord(instrWord),
    .dbgR0(dbgR0), .dbgR1(dbgR1), .dbgR2(dbgR2),
    .dbgA(dbgA), .dbgB(dbgB), .dbgZ(dbgZ)
  );

  typedef struct packed {
    logic [15:0] ins;
    logic [7:0]  r0, r1, r2, a, b;
    logic        z;
    logic [7:0]  pc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  // expected state after each instruction, run in order
  localparam vec_t VECS [NV] = '{
    '{16'h130A, 8'd10, 8'd0,  8'd0,  8'd0,   8'd0,   1'b0, 8'h01, 4'd3}, // R3 imm
    '{16'h1705, 8'd10, 8'd5,  8'd0,  8'd0,   8'd0,   1'b0, 8'h02, 4'd3},
    '{16'h2000, 8'd10, 8'd5,  8'd0,  8'd10,  8'd0,   1'b0, 8'h03, 4'd4}, // R4 A<-R0
    '{16'h2501, 8'd10, 8'd5,  8'd0,  8'd10,  8'd5,   1'b0, 8'h04, 4'd4}, // R4 B<-R1
    '{16'h4800, 8'd10, 8'd5,  8'd15, 8'd10,  8'd5,   1'b0, 8'h05, 4'd5}, // R5 add
    '{16'h4100, 8'd5,  8'd5,  8'd15, 8'd10,  8'd5,   1'b0, 8'h06, 4'd5}, // R5 sub
    '{16'h3305, 8'd5,  8'd5,  8'd15, 8'd5,   8'd5,   1'b0, 8'h07, 4'd4},
    '{16'h4D00, 8'd5,  8'd5,  8'd15, 8'd5,   8'd5,   1'b1, 8'h08, 4'd6}, // R6 cmp equal
    '{16'h0000, 8'd5,  8'd5,  8'd15, 8'd5,   8'd5,   1'b1, 8'h09, 4'd8}, // R8 nop keeps Z
    '{16'hFC20, 8'd5,  8'd5,  8'd15, 8'd5,   8'd5,   1'b1, 8'h20, 4'd7}, // R7 BEQ taken
    '{16'hF840, 8'd5,  8'd5,  8'd15, 8'd5,   8'd5,   1'b1, 8'h21, 4'd7}, // R7 BNE not taken
    '{16'h4400, 8'd5,  8'd10, 8'd15, 8'd5,   8'd5,   1'b0, 8'h22, 4'd5},
    '{16'hF840, 8'd5,  8'd10, 8'd15, 8'd5,   8'd5,   1'b0, 8'h40, 4'd7}, // R7 BNE taken
    '{16'hFC00, 8'd5,  8'd10, 8'd15, 8'd5,   8'd5,   1'b0, 8'h41, 4'd7}, // R7 BEQ not taken
    '{16'hF0FF, 8'd5,  8'd10, 8'd15, 8'd5,   8'd5,   1'b0, 8'hFF, 4'd7}, // R7 BRA
    '{16'h0000, 8'd5,  8'd10, 8'd15, 8'd5,   8'd5,   1'b0, 8'h00, 4'd2}, // R2 PC wrap
    '{16'h37FF, 8'd5,  8'd10, 8'd15, 8'd5,   8'd255, 1'b0, 8'h01, 4'd4},
    '{16'h3301, 8'd5,  8'd10, 8'd15, 8'd1,   8'd255, 1'b0, 8'h02, 4'd4},
    '{16'h4000, 8'd0,  8'd10, 8'd15, 8'd1,   8'd255, 1'b1, 8'h03, 4'd5}, // R5 add wraps to 0
    '{16'h3300, 8'd0,  8'd10, 8'd15, 8'd0,   8'd255, 1'b1, 8'h04, 4'd8}, // R8
    '{16'h4100, 8'd1,  8'd10, 8'd15, 8'd0,   8'd255, 1'b0, 8'h05, 4'd5}, // R5 borrow
    '{16'h33FF, 8'd1,  8'd10, 8'd15, 8'd255, 8'd255, 1'b0, 8'h06, 4'd4},
    '{16'h4D00, 8'd1,  8'd10, 8'd15, 8'd255, 8'd255, 1'b1, 8'h07, 4'd6}, // R6 no reg write
    '{16'h4C00, 8'd1,  8'd10, 8'd15, 8'd255, 8'd255, 1'b1, 8'h08, 4'd9}, // R9 add dst 3
    '{16'h0C00, 8'd1,  8'd10, 8'd15, 8'd255, 8'd255, 1'b1, 8'h09, 4'd9}, // R9 move dst 3
    '{16'h0700, 8'd1,  8'd10, 8'd15, 8'd255, 8'd255, 1'b1, 8'h0A, 4'd9}, // R9 src 3 no imm
    '{16'h0800, 8'd1,  8'd10, 8'd1,  8'd255, 8'd255, 1'b1, 8'h0B, 4'd3}, // R3 reg copy
    '{16'h6000, 8'd1,  8'd10, 8'd1,  8'd255, 8'd255, 1'b1, 8'h0C, 4'd9}, // R9 unused class
    '{16'h2800, 8'd1,  8'd10, 8'd1,  8'd255, 8'd255, 1'b1, 8'h0D, 4'd9}, // R9 ALU move bit3
    '{16'h1B77, 8'd1,  8'd10, 8'h77, 8'd255, 8'd255, 1'b1, 8'h0E, 4'd3},
    '{16'h2602, 8'd1,  8'd10, 8'h77, 8'd255, 8'h77,  1'b1, 8'h0F, 4'd4}
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkState(int req, vec_t v);
    string t;
    t = $sformatf("R%0d ins %04h", req, v.ins);
    check({t, " R0"}, dbgR0, v.r0);
    check({t, " R1"}, dbgR1, v.r1);
    check({t, " R2"}, dbgR2, v.r2);
    check({t, " A"},  dbgA,  v.a);
    check({t, " B"},  dbgB,  v.b);
    check({t, " Z"},  {7'd0, dbgZ}, {7'd0, v.z});
    check({t, " PC"}, instrAddr, v.pc);
  endtask

  // runs one instruction; called at a negedge in a fetch cycle
  task automatic runInstr(logic [15:0] w);
    logic [7:0] pcBefore;
    pcBefore  = instrAddr;
    instrWord = w;
    @(posedge clk);
    @(negedge clk);
    check("R2 addr stable in execute", instrAddr, pcBefore);
    instrWord = 16'hFFFF;   // would branch if sampled now
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkState(1, '{16'h0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0, 4'd1});
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      runInstr(VECS[i].ins);
      checkState(int'(VECS[i].req), VECS[i]);
    end

    // R1: reset in mid-run clears everything
    rstN = 1'b0;
    @(negedge clk);
    checkState(1, '{16'h0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0, 4'd1});
    @(negedge clk);
    rstN = 1'b1;

    // R3: first instruction after reset runs normally
    runInstr(16'h1701);
    checkState(3, '{16'h1701, 8'd0, 8'd1, 8'd0, 8'd0, 8'd0, 1'b0, 8'd1, 4'd3});

    // R6: compare with unequal operands clears Z, no write
    runInstr(16'h3703);
    runInstr(16'h4D00);
    checkState(6, '{16'h4D00, 8'd0, 8'd1, 8'd0, 8'd0, 8'd3, 1'b0, 8'd3, 4'd6});

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule